// File: doc/BRIEF.md
# AXI Master-Port Region Decoder with Decode-Error Slave

This block sits at the entry of one master port of an AXI4 interconnect. It compares every write and read address against a table of slave windows and names the target with a one-hot select. Software programs the table at run time and can read it back. Each window holds a base, a size, a reserved flag and a mask of the master numbers allowed to use it.

An address can miss every window, land in a reserved window, or come from a master that the window's mask excludes. Such an access is never forwarded. An internal error slave takes it and completes it with the decode-error response code. For a write, the error slave accepts the address, discards every data beat up to the last one, and returns one write response. For a read, it returns the requested number of beats with zero data.

Until software sets the initialised bit, the block accepts no address handshake on either channel. Each channel carries at most one transaction at a time.

Top module: `axi_region_decoder`

## Requirements
- R1: Window i contains an address A when base_i <= A < base_i + size_i, compared without wrap. A window of size 0 contains nothing. A routed address drives a one-hot fwd_aw_sel/fwd_ar_sel, with bit i set for window i, and raises fwd_awvalid/fwd_arvalid while the address is valid.
- R2: When several windows contain the address, only the lowest-numbered one decides the outcome, including its reserved flag and mask.
- R3: An address that no window contains is not forwarded. fwd_*valid stays low, the select is zero, and the error slave accepts the address.
- R4: A deciding window whose reserved flag (flags field, bit 0) is 1 gives the same outcome as a miss.
- R5: A deciding window whose permission mask bit at index master_id is 0 gives the same outcome as a miss.
- R6: The configuration port writes on cfg_we and reads back combinationally on cfg_rdata. cfg_addr bit 4 = 1 selects the control word, whose bit 0 is init-done. Otherwise cfg_addr[3:2] is the window index and cfg_addr[1:0] the field: 0 base, 1 size, 2 flags, 3 permission mask. The mask reads back zero-extended. All fields reset to 0.
- R7: While init-done is 0, s_awready, s_arready, fwd_awvalid and fwd_arvalid are all 0.
- R8: An errored write accepts AW and then asserts s_wready until the beat with s_wlast has been accepted. It then gives one B beat with s_bresp = 2'b11 (DECERR; OKAY is 2'b00, SLVERR 2'b10) and s_bid equal to the captured AWID. No B beat appears before the last W beat.
- R9: An errored read gives s_arlen+1 R beats, each with s_rresp = 2'b11, s_rdata = 0 and s_rid equal to the captured ARID. s_rlast is 1 on the final beat only.
- R10: From an errored AW (or AR) handshake until its response handshake, s_awready (or s_arready) is 0. A response that has not been accepted keeps its valid and every field stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_id | input | 2 | Number of the master on this port, used to index the permission masks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 32 | Write address |
| s_awid | input | 4 | Write ID |
| s_wvalid | input | 1 | Write data valid, errored path |
| s_wlast | input | 1 | Last write beat |
| s_wready | output | 1 | Write data ready from the error slave |
| s_bvalid | output | 1 | Error write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | 4 | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 32 | Read address |
| s_arid | input | 4 | Read ID |
| s_arlen | input | 8 | Read burst length minus one |
| s_rvalid | output | 1 | Error read data valid |
| s_rready | input | 1 | Read data ready |
| s_rid | output | 4 | Read ID |
| s_rdata | output | 32 | Read data (zero) |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| fwd_awvalid | output | 1 | Routed write address valid |
| fwd_awready | input | 1 | Routed write address ready from the slave side |
| fwd_aw_sel | output | 4 | One-hot write target window |
| fwd_arvalid | output | 1 | Routed read address valid |
| fwd_arready | input | 1 | Routed read address ready from the slave side |
| fwd_ar_sel | output | 4 | One-hot read target window |

## Verification
The decode is combinational, so a wrong table entry or a wrong priority shows up on the select outputs in the same cycle the address is presented. The bench compares both selects against its own model on every clock. A stuck error-slave state shows within one handshake. It appears as a missing or early B beat, a wrong R beat count or misplaced RLAST, or an address ready that stays low or rises while a response is still pending. A lost initialisation bit shows as ready on the very first address presented.

// File: rtl/axi_dec_pkg.sv
package axi_dec_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_SIZE  = 2'd1,
    FLD_FLAGS = 2'd2,
    FLD_MASK  = 2'd3
  } field_e;
endpackage

// File: rtl/region_table.sv
module region_table #(
  parameter int N_REG  = 4,
  parameter int N_MST  = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(N_REG),
  localparam int CFG_AW = IDX_W + 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [ADDR_W-1:0]                 cfg_rdata,
  output logic                              init_done,
  output logic [N_REG-1:0][ADDR_W-1:0]      base,
  output logic [N_REG-1:0][ADDR_W-1:0]      size,
  output logic [N_REG-1:0]                  rsv,
  output logic [N_REG-1:0][N_MST-1:0]       mask
);
  import axi_dec_pkg::*;

  logic             sel_ctl;
  logic [IDX_W-1:0] sel_idx;
  field_e           sel_fld;
  logic             idx_ok;

  assign sel_ctl = cfg_addr[CFG_AW-1];
  assign sel_idx = cfg_addr[IDX_W+1:2];
  assign sel_fld = field_e'(cfg_addr[1:0]);
  assign idx_ok  = int'(sel_idx) < N_REG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      base      <= '0;
      size      <= '0;
      rsv       <= '0;
      mask      <= '0;
    end else if (cfg_we) begin
      if (sel_ctl) init_done <= cfg_wdata[0];
      else if (idx_ok) begin
        case (sel_fld)
          FLD_BASE:  base[sel_idx] <= cfg_wdata;
          FLD_SIZE:  size[sel_idx] <= cfg_wdata;
          FLD_FLAGS: rsv[sel_idx]  <= cfg_wdata[0];
          default:   mask[sel_idx] <= cfg_wdata[N_MST-1:0];
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_ctl) cfg_rdata[0] = init_done;
    else if (idx_ok) begin
      case (sel_fld)
        FLD_BASE:  cfg_rdata = base[sel_idx];
        FLD_SIZE:  cfg_rdata = size[sel_idx];
        FLD_FLAGS: cfg_rdata[0] = rsv[sel_idx];
        default:   cfg_rdata[N_MST-1:0] = mask[sel_idx];
      endcase
    end
  end
endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int N_REG  = 4,
  parameter int N_MST  = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(N_REG),
  localparam int MID_W = $clog2(N_MST)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [MID_W-1:0]             master_id,
  input  logic [N_REG-1:0][ADDR_W-1:0] base,
  input  logic [N_REG-1:0][ADDR_W-1:0] size,
  input  logic [N_REG-1:0]             rsv,
  input  logic [N_REG-1:0][N_MST-1:0]  mask,
  output logic [N_REG-1:0]             sel,
  output logic                         deny
);
  function automatic logic in_window(logic [ADDR_W-1:0] a,
                                     logic [ADDR_W-1:0] b,
                                     logic [ADDR_W-1:0] s);
    return (a >= b) && ((a - b) < s);
  endfunction

  logic             hit_found;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    hit_found = 1'b0;
    hit_idx   = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (!hit_found && in_window(addr, base[i], size[i])) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
    end
  end

  assign deny = !hit_found || rsv[hit_idx] || !mask[hit_idx][master_id];

  for (genvar j = 0; j < N_REG; j++) begin : g_sel
    assign sel[j] = !deny && (hit_idx == IDX_W'(j));
  end

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (deny || $onehot(sel)));
endmodule

// File: rtl/err_write.sv
module err_write #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] id,
  input  logic            wvalid,
  input  logic            wlast,
  output logic            wready,
  output logic            bvalid,
  input  logic            bready,
  output logic [ID_W-1:0] bid,
  output logic [1:0]      bresp,
  output logic            idle
);
  import axi_dec_pkg::*;

  typedef enum logic [1:0] {W_IDLE, W_DRAIN, W_RESP} wst_e;
  wst_e            st;
  logic [ID_W-1:0] id_q;
  logic            drain_done;
  logic            b_done;

  assign drain_done = (st == W_DRAIN) && wvalid && wlast;
  assign b_done     = (st == W_RESP) && bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      id_q <= '0;
    end else begin
      case (st)
        W_IDLE:  if (start) begin st <= W_DRAIN; id_q <= id; end
        W_DRAIN: if (drain_done) st <= W_RESP;
        default: if (b_done) st <= W_IDLE;
      endcase
    end
  end

  assign idle   = (st == W_IDLE);
  assign wready = (st == W_DRAIN);
  assign bvalid = (st == W_RESP);
  assign bid    = id_q;
  assign bresp  = RESP_DECERR;

  p_b_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bid) && $stable(bresp));
  p_b_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> $past(wvalid && wready && wlast));
endmodule

// File: rtl/err_read.sv
module err_read #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ID_W-1:0]   id,
  input  logic [LEN_W-1:0]  len,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              idle
);
  import axi_dec_pkg::*;

  logic             busy;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] beat;
  logic             beat_done;

  assign beat_done = busy && rready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      id_q  <= '0;
      len_q <= '0;
      beat  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        id_q  <= id;
        len_q <= len;
        beat  <= '0;
      end
    end else if (beat_done) begin
      if (beat == len_q) busy <= 1'b0;
      else beat <= beat + 1'b1;
    end
  end

  assign idle   = !busy;
  assign rvalid = busy;
  assign rid    = id_q;
  assign rdata  = '0;
  assign rresp  = RESP_DECERR;
  assign rlast  = busy && (beat == len_q);

  p_r_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rid) && $stable(rlast));
  p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rready && rlast |=> !rvalid);
endmodule

// File: rtl/axi_region_decoder.sv
module axi_region_decoder #(
  parameter int N_REG  = 4,
  parameter int N_MST  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  localparam int MID_W  = $clog2(N_MST),
  localparam int CFG_AW = $clog2(N_REG) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MID_W-1:0]  master_id,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [ID_W-1:0]   s_awid,
  input  logic              s_wvalid,
  input  logic              s_wlast,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              fwd_awvalid,
  input  logic              fwd_awready,
  output logic [N_REG-1:0]  fwd_aw_sel,
  output logic              fwd_arvalid,
  input  logic              fwd_arready,
  output logic [N_REG-1:0]  fwd_ar_sel
);
  logic                         init_done;
  logic [N_REG-1:0][ADDR_W-1:0] base;
  logic [N_REG-1:0][ADDR_W-1:0] size;
  logic [N_REG-1:0]             rsv;
  logic [N_REG-1:0][N_MST-1:0]  mask;
  logic aw_deny, ar_deny, aw_idle, ar_idle;
  logic aw_open, ar_open, aw_err_take, ar_err_take;

  region_table #(.N_REG(N_REG), .N_MST(N_MST), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .init_done(init_done),
    .base(base), .size(size), .rsv(rsv), .mask(mask));

  addr_decode #(.N_REG(N_REG), .N_MST(N_MST), .ADDR_W(ADDR_W)) u_aw_dec (
    .clk(clk), .rst_n(rst_n), .addr(s_awaddr), .master_id(master_id),
    .base(base), .size(size), .rsv(rsv), .mask(mask),
    .sel(fwd_aw_sel), .deny(aw_deny));

  addr_decode #(.N_REG(N_REG), .N_MST(N_MST), .ADDR_W(ADDR_W)) u_ar_dec (
    .clk(clk), .rst_n(rst_n), .addr(s_araddr), .master_id(master_id),
    .base(base), .size(size), .rsv(rsv), .mask(mask),
    .sel(fwd_ar_sel), .deny(ar_deny));

  assign aw_open     = init_done && aw_idle;
  assign ar_open     = init_done && ar_idle;
  assign aw_err_take = s_awvalid && aw_open && aw_deny;
  assign ar_err_take = s_arvalid && ar_open && ar_deny;
  assign s_awready   = aw_open && (aw_deny || fwd_awready);
  assign s_arready   = ar_open && (ar_deny || fwd_arready);
  assign fwd_awvalid = s_awvalid && aw_open && !aw_deny;
  assign fwd_arvalid = s_arvalid && ar_open && !ar_deny;

  err_write #(.ID_W(ID_W)) u_err_w (
    .clk(clk), .rst_n(rst_n), .start(aw_err_take), .id(s_awid),
    .wvalid(s_wvalid), .wlast(s_wlast), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready), .bid(s_bid), .bresp(s_bresp),
    .idle(aw_idle));

  err_read #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_err_r (
    .clk(clk), .rst_n(rst_n), .start(ar_err_take), .id(s_arid), .len(s_arlen),
    .rvalid(s_rvalid), .rready(s_rready), .rid(s_rid), .rdata(s_rdata),
    .rresp(s_rresp), .rlast(s_rlast), .idle(ar_idle));

  p_init_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !s_awready && !s_arready && !fwd_awvalid && !fwd_arvalid);
  p_aw_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wready || s_bvalid) |-> !s_awready && !fwd_awvalid);
  p_ar_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready && !fwd_arvalid);
  p_fwd_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_awvalid |-> $onehot(fwd_aw_sel)) and (fwd_arvalid |-> $onehot(fwd_ar_sel)));
endmodule

// File: tb/tb_axi_region_decoder.sv
module tb_axi_region_decoder;
  localparam int PERIOD = 10;
  localparam int NR = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0]  master_id = 2'd1;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic s_awvalid = 0, s_awready, s_wvalid = 0, s_wlast = 0, s_wready;
  logic [31:0] s_awaddr = 0, s_araddr = 0, s_rdata;
  logic [3:0]  s_awid = 0, s_arid = 0, s_bid, s_rid;
  logic s_bvalid, s_bready = 0, s_arvalid = 0, s_arready, s_rvalid, s_rready = 0, s_rlast;
  logic [1:0]  s_bresp, s_rresp;
  logic [7:0]  s_arlen = 0;
  logic fwd_awvalid, fwd_awready = 0, fwd_arvalid, fwd_arready = 0;
  logic [3:0] fwd_aw_sel, fwd_ar_sel;

  axi_region_decoder dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  longint m_base[NR], m_size[NR];
  bit m_rsv[NR];
  bit [3:0] m_mask[NR];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model: scan from the top so the lowest containing window is the last writer
  function automatic bit [3:0] model_sel(longint a);
    int win = -1;
    for (int i = NR - 1; i >= 0; i--)
      if (a >= m_base[i] && a < m_base[i] + m_size[i]) win = i;
    if (win < 0 || m_rsv[win] || !m_mask[win][master_id]) return 4'b0;
    return 4'b1 << win;
  endfunction

  // per-clock comparison of both selects (R1, R2, R4, R5)
  always @(negedge clk) if (rst_n && !done) begin
    chk(fwd_aw_sel == model_sel(s_awaddr), "R1/R2 aw_sel", fwd_aw_sel, model_sel(s_awaddr));
    chk(fwd_ar_sel == model_sel(s_araddr), "R1/R2 ar_sel", fwd_ar_sel, model_sel(s_araddr));
  end

  task automatic cfg_wr(int idx, int fld, longint d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 5'(idx * 4 + fld); cfg_wdata = 32'(d);
    @(posedge clk); #1;
    cfg_we = 0;
    case (fld)
      0: m_base[idx] = d;
      1: m_size[idx] = d;
      2: m_rsv[idx] = d[0];
      default: m_mask[idx] = 4'(d);
    endcase
  endtask

  task automatic aw_send(logic [31:0] a, logic [3:0] id);
    @(posedge clk); #1;
    s_awvalid = 1; s_awaddr = a; s_awid = id;
    do @(negedge clk); while (!s_awready);
    @(posedge clk); #1;
    s_awvalid = 0;
  endtask

  task automatic ar_send(logic [31:0] a, logic [3:0] id, logic [7:0] len);
    @(posedge clk); #1;
    s_arvalid = 1; s_araddr = a; s_arid = id; s_arlen = len;
    do @(negedge clk); while (!s_arready);
    @(posedge clk); #1;
    s_arvalid = 0;
  endtask

  task automatic err_write_check(logic [31:0] a, logic [3:0] id, int beats, string req);
    aw_send(a, id);
    for (int b = 0; b < beats; b++) begin
      s_wvalid = 1; s_wlast = (b == beats - 1);
      @(negedge clk);
      chk(s_wready == 1, {req, " R8 wready"}, s_wready, 1);
      chk(s_bvalid == 0, "R8 no early B", s_bvalid, 0);
      @(posedge clk); #1;
    end
    s_wvalid = 0; s_wlast = 0;
    @(negedge clk);
    chk(s_bvalid == 1 && s_bresp == 2'b11, {req, " R8 bresp"}, {s_bvalid, s_bresp}, 3'b111);
    chk(s_bid == id, "R8 bid", s_bid, id);
    chk(s_awready == 0, "R10 awready while pending", s_awready, 0);
    @(negedge clk);
    chk(s_bvalid == 1 && s_bid == id, "R10 B held", s_bid, id);
    @(posedge clk); #1; s_bready = 1;
    @(posedge clk); #1; s_bready = 0;
    @(negedge clk);
    chk(s_bvalid == 0, "R8 single B", s_bvalid, 0);
  endtask

  task automatic err_read_check(logic [31:0] a, logic [3:0] id, int len, string req);
    int beats = 0;
    ar_send(a, id, 8'(len));
    @(negedge clk);
    chk(s_rvalid == 1 && s_arready == 0, {req, " R10 rvalid/arready"}, {s_rvalid, s_arready}, 2'b10);
    @(posedge clk); #1; s_rready = 1;
    forever begin
      @(negedge clk);
      if (!s_rvalid) break;
      beats++;
      chk(s_rresp == 2'b11 && s_rdata == 0 && s_rid == id, "R9 beat fields",
          {s_rresp, s_rid}, {2'b11, id});
      chk(s_rlast == (beats == len + 1), "R9 rlast", s_rlast, beats == len + 1);
      if (s_rlast) begin @(posedge clk); #1; s_rready = 0; @(negedge clk); break; end
    end
    chk(beats == len + 1, "R9 beat count", beats, len + 1);
    chk(s_rvalid == 0, "R9 done", s_rvalid, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_size[i] = 0; m_rsv[i] = 0; m_mask[i] = 0; end
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(s_bvalid == 0 && s_rvalid == 0, "R6 reset outputs", {s_bvalid, s_rvalid}, 0);
    cfg_addr = 5'h10; #1;
    chk(cfg_rdata == 0, "R6 ctl reset", cfg_rdata, 0);
    // R7: nothing accepted before init
    cfg_wr(0, 0, 32'h1000); cfg_wr(0, 1, 32'h1000); cfg_wr(0, 3, 4'b0010);
    @(posedge clk); #1; s_awvalid = 1; s_awaddr = 32'h1100; s_arvalid = 1; s_araddr = 32'h9000; fwd_awready = 1;
    @(negedge clk);
    chk(s_awready == 0 && fwd_awvalid == 0 && s_arready == 0, "R7 gate", {s_awready, fwd_awvalid, s_arready}, 0);
    @(posedge clk); #1; s_awvalid = 0; s_arvalid = 0; fwd_awready = 0;
    cfg_wr(1, 0, 32'h1800); cfg_wr(1, 1, 32'h1000); cfg_wr(1, 3, 4'b1111);
    cfg_wr(2, 0, 32'h4000); cfg_wr(2, 1, 32'h100);  cfg_wr(2, 3, 4'b1111); cfg_wr(2, 2, 1);
    cfg_wr(3, 0, 32'h8000); cfg_wr(3, 1, 32'h100);  cfg_wr(3, 3, 4'b0001);
    // R6 readback
    cfg_addr = 5'(1 * 4 + 0); #1; chk(cfg_rdata == 32'h1800, "R6 base readback", cfg_rdata, 32'h1800);
    cfg_addr = 5'(2 * 4 + 2); #1; chk(cfg_rdata == 1, "R6 flags readback", cfg_rdata, 1);
    cfg_addr = 5'(3 * 4 + 3); #1; chk(cfg_rdata == 1, "R6 mask readback", cfg_rdata, 1);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = 5'h10; cfg_wdata = 1;
    @(posedge clk); #1; cfg_we = 0; #1;
    chk(cfg_rdata == 1, "R6 init readback", cfg_rdata, 1);
    // R1/R2 routed: overlap goes to window 0; slave ready governs accept
    @(posedge clk); #1; s_awvalid = 1; s_awaddr = 32'h1900;
    @(negedge clk);
    chk(fwd_awvalid == 1 && fwd_aw_sel == 4'b0001 && s_awready == 0, "R2 overlap routed",
        {fwd_awvalid, fwd_aw_sel, s_awready}, 6'b100010);
    @(posedge clk); #1; fwd_awready = 1;
    @(negedge clk); chk(s_awready == 1, "R1 accept via slave", s_awready, 1);
    @(posedge clk); #1; s_awvalid = 0; fwd_awready = 0;
    s_awaddr = 32'h1fff; @(negedge clk); chk(fwd_aw_sel == 4'b0001, "R1 top edge", fwd_aw_sel, 1);
    s_awaddr = 32'h2400; @(negedge clk); chk(fwd_aw_sel == 4'b0010, "R1 window 1", fwd_aw_sel, 2);
    s_awaddr = 32'h2800; @(negedge clk); chk(fwd_aw_sel == 0, "R3 past end", fwd_aw_sel, 0);
    @(posedge clk); #1; s_arvalid = 1; s_araddr = 32'h2000; fwd_arready = 1;
    @(negedge clk); chk(fwd_arvalid && fwd_ar_sel == 4'b0010 && s_arready, "R1 read routed", fwd_ar_sel, 2);
    @(posedge clk); #1; s_arvalid = 0; fwd_arready = 0;
    // errored writes
    err_write_check(32'h9000, 4'd5, 3, "R3 unmapped");
    err_write_check(32'h4010, 4'd9, 1, "R4 reserved");
    err_write_check(32'h8000, 4'd2, 2, "R5 denied");
    // errored reads
    err_read_check(32'h0fff, 4'd7, 0, "R3 read unmapped");
    err_read_check(32'h4000, 4'd3, 2, "R4 read reserved");
    err_read_check(32'h80ff, 4'd12, 4, "R5 read denied");
    // R5: another master id allowed into window 3
    master_id = 2'd0; s_araddr = 32'h8000;
    @(negedge clk); chk(fwd_ar_sel == 4'b1000, "R5 allowed master", fwd_ar_sel, 8);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule